// File: doc/BRIEF.md
# Serial Receive FIFO Status Controller

This block sits beside a serial port's shifter. It keeps a 16-deep receive queue in which every character carries its own line-condition tags: break, framing, parity and overrun. It also assembles a 32-bit status word for software and drives one interrupt line. A character strobe pushes data and tags into the queue. Reading the data register pops the head, and the status word always describes that head entry.

The status word also holds five sticky event bits:
- a receive-error event;
- a receive time-out;
- a transmit request, raised when transmit free space meets a programmable level;
- a receive request, raised when queue occupancy meets a programmable level;
- a status-change summary over a selectable subset of the other four.

Software clears an event bit by writing 0 to its position. The interrupt output is raised while any event bit is set. A one-bit select on a simple read/write port picks between the data register and the status register.

Top module: `rxfifo_status_ctrl`

## Requirements
- R1: The receive queue holds up to 16 characters in arrival order. Status bits 4:0 give the occupancy (0 to 16). A read with `reg_sel_i`=0 returns the head character in `reg_rdata_o[7:0]` and pops it when the queue is not empty.
- R2: Status bits 15 (break), 13 (framing), 12 (parity) and 11 (overrun) show the tags of the head entry. They advance on each pop and read 0 while the queue is empty.
- R3: Status bit 14 reads 1 when the queue is empty and 0 otherwise. It is 1 after reset.
- R4: A character that arrives while the queue is full, with no pop in the same cycle, is dropped and the occupancy stays 16. The overrun tag is set on the newest stored entry. If a pop coincides with that arrival, the character is stored normally.
- R5: Status bit 10 sets on the edge that accepts a character tagged with a framing or parity error, or on an overrun. A break tag alone does not set it.
- R6: Status bit 9 sets on the edge after a `rx_timeout_i` pulse.
- R7: Status bit 8 sets while `tx_free_i` >= `tx_trig_i`. It is 1 after reset.
- R8: Status bit 7 sets while occupancy >= `rx_trig_i`. The comparison uses the registered occupancy, so the bit follows one edge later.
- R9: Status bit 6 sets when an event bit selected in `stat_mask_i` goes from 0 to 1. Mask bit 3 selects bit 10, bit 2 selects bit 9, bit 1 selects bit 8 and bit 0 selects bit 7.
- R10: A write with `reg_sel_i`=1 clears each of bits 10..6 whose write-data bit is 0 and leaves the others. No other status bit is writable. A set condition in the same cycle as a clear wins.
- R11: `irq_o` is 1 exactly when any of status bits 10..6 is 1.
- R12: Status bits 31:16 and bit 5 always read 0. After reset the status word is 0x00004100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received-character strobe |
| rx_data_i | input | 8 | Received character |
| rx_brk_i | input | 1 | Break tag for the character |
| rx_ferr_i | input | 1 | Framing-error tag |
| rx_perr_i | input | 1 | Parity-error tag |
| rx_timeout_i | input | 1 | Receive time-out pulse |
| tx_free_i | input | 5 | Transmit FIFO free entries |
| tx_trig_i | input | 5 | Transmit request level |
| rx_trig_i | input | 5 | Receive request level |
| stat_mask_i | input | 4 | Status-change source select |
| reg_sel_i | input | 1 | 0 selects data register, 1 selects status register |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational |
| status_o | output | 32 | Status word |
| irq_o | output | 1 | Interrupt |

## Verification
Two groups of events can fall in the same clock cycle.

The first is a pop and a push into a full queue. The bench fills the queue, then raises the character strobe and the data-register read on the same edge. It expects the occupancy to stay at 16, no receive-error event, no overrun tag, and the new character to drain last.

The second is an event set and a software write-0 clear of the same bit. The bench pulses the time-out while writing 0 to the status register and expects bit 9 still set. A later write with no pulse must clear it.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic       oerr;
    logic [7:0] data;
  } rx_ent_t;

  localparam int unsigned BIT_BRK   = 15;
  localparam int unsigned BIT_EMPTY = 14;
  localparam int unsigned BIT_FERR  = 13;
  localparam int unsigned BIT_PERR  = 12;
  localparam int unsigned BIT_OERR  = 11;
  localparam int unsigned BIT_ERR   = 10;
  localparam int unsigned BIT_TOUT  = 9;
  localparam int unsigned BIT_TXREQ = 8;
  localparam int unsigned BIT_RXREQ = 7;
  localparam int unsigned BIT_STCHG = 6;

  // event vector order: source bits low, summary on top
  localparam int unsigned EV_RXREQ = 0;
  localparam int unsigned EV_TXREQ = 1;
  localparam int unsigned EV_TOUT  = 2;
  localparam int unsigned EV_ERR   = 3;
  localparam int unsigned EV_NSRC  = 4;
endpackage

// File: rtl/rxs_fifo.sv
module rxs_fifo
  import rxs_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  rx_ent_t       ent_i,
  input  logic          pop_i,
  output rx_ent_t       head_o,
  output logic [CW-1:0] cnt_o,
  output logic          empty_o,
  output logic          ovr_o
);
  rx_ent_t       mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, last_ptr;
  logic [CW-1:0] cnt_q;
  logic          full, do_push, do_pop;

  assign full     = (cnt_q == CW'(DEPTH));
  assign empty_o  = (cnt_q == '0);
  assign do_pop   = pop_i & ~empty_o;
  assign do_push  = push_i & (~full | do_pop);
  assign ovr_o    = push_i & full & ~do_pop;
  assign last_ptr = (wr_ptr == '0) ? AW'(DEPTH - 1) : wr_ptr - 1'b1;

  function automatic logic [AW-1:0] nxt_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= ent_i;
    else if (ovr_o) mem[last_ptr].oerr <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= nxt_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o = mem[rd_ptr];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/rxs_event_regs.sv
module rxs_event_regs #(
  parameter int NSRC = 4,
  parameter logic [NSRC:0] RST_VAL = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC:0]   clr_i,
  input  logic [NSRC-1:0] mask_i,
  output logic [NSRC:0]   q_o
);
  logic [NSRC:0]   q, nxt;
  logic [NSRC-1:0] rise;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign nxt[i]  = (q[i] & ~clr_i[i]) | set_i[i];
    assign rise[i] = nxt[i] & ~q[i];
  end

  // summary bit: set on a selected 0->1 transition
  assign nxt[NSRC] = (q[NSRC] & ~clr_i[NSRC]) | |(rise & mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= RST_VAL;
    else         q <= nxt;
  end

  assign q_o = q;
endmodule

// File: rtl/rxfifo_status_ctrl.sv
module rxfifo_status_ctrl
  import rxs_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_brk_i,
  input  logic          rx_ferr_i,
  input  logic          rx_perr_i,
  input  logic          rx_timeout_i,
  input  logic [CW-1:0] tx_free_i,
  input  logic [CW-1:0] tx_trig_i,
  input  logic [CW-1:0] rx_trig_i,
  input  logic [3:0]    stat_mask_i,
  input  logic          reg_sel_i,
  input  logic          reg_rd_i,
  input  logic          reg_wr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic [31:0]   status_o,
  output logic          irq_o
);
  localparam logic [EV_NSRC:0] EV_RST = (EV_NSRC + 1)'(1) << EV_TXREQ;

  rx_ent_t          in_ent, head_raw, head;
  logic [CW-1:0]    cnt;
  logic             empty, ovr, pop;
  logic [EV_NSRC-1:0] ev_set;
  logic [EV_NSRC:0]   ev_clr, ev_q;
  logic             stat_wr;

  assign pop    = reg_rd_i & ~reg_sel_i;
  assign in_ent = '{brk: rx_brk_i, ferr: rx_ferr_i, perr: rx_perr_i,
                    oerr: 1'b0, data: rx_data_i};

  rxs_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_valid_i),
    .ent_i   (in_ent),
    .pop_i   (pop),
    .head_o  (head_raw),
    .cnt_o   (cnt),
    .empty_o (empty),
    .ovr_o   (ovr)
  );

  assign head = empty ? '0 : head_raw;

  always_comb begin
    ev_set           = '0;
    ev_set[EV_ERR]   = (rx_valid_i & (rx_ferr_i | rx_perr_i)) | ovr;
    ev_set[EV_TOUT]  = rx_timeout_i;
    ev_set[EV_TXREQ] = (tx_free_i >= tx_trig_i);
    ev_set[EV_RXREQ] = (cnt >= rx_trig_i);
  end

  assign stat_wr = reg_wr_i & reg_sel_i;

  always_comb begin
    ev_clr = '0;
    if (stat_wr) begin
      ev_clr[EV_ERR]   = ~reg_wdata_i[BIT_ERR];
      ev_clr[EV_TOUT]  = ~reg_wdata_i[BIT_TOUT];
      ev_clr[EV_TXREQ] = ~reg_wdata_i[BIT_TXREQ];
      ev_clr[EV_RXREQ] = ~reg_wdata_i[BIT_RXREQ];
      ev_clr[EV_NSRC]  = ~reg_wdata_i[BIT_STCHG];
    end
  end

  rxs_event_regs #(.NSRC(EV_NSRC), .RST_VAL(EV_RST)) u_ev (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ev_set),
    .clr_i  (ev_clr),
    .mask_i (stat_mask_i),
    .q_o    (ev_q)
  );

  always_comb begin
    status_o            = '0;
    status_o[BIT_BRK]   = head.brk;
    status_o[BIT_EMPTY] = empty;
    status_o[BIT_FERR]  = head.ferr;
    status_o[BIT_PERR]  = head.perr;
    status_o[BIT_OERR]  = head.oerr;
    status_o[BIT_ERR]   = ev_q[EV_ERR];
    status_o[BIT_TOUT]  = ev_q[EV_TOUT];
    status_o[BIT_TXREQ] = ev_q[EV_TXREQ];
    status_o[BIT_RXREQ] = ev_q[EV_RXREQ];
    status_o[BIT_STCHG] = ev_q[EV_NSRC];
    status_o[CW-1:0]    = cnt;
  end

  assign reg_rdata_o = reg_sel_i ? status_o : {24'h0, head.data};
  assign irq_o       = |ev_q;

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata_i[31:11], reg_wdata_i[5:0]};
endmodule

// File: rtl/rxs_status_chk.sv
module rxs_status_chk #(
  parameter int DEPTH = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rx_valid_i,
  input logic        rx_ferr_i,
  input logic        rx_perr_i,
  input logic        rx_timeout_i,
  input logic        reg_sel_i,
  input logic        reg_rd_i,
  input logic        reg_wr_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] status_i,
  input logic        irq_i
);
  logic [4:0] cnt;
  logic       rd_pop;
  assign cnt    = status_i[4:0];
  assign rd_pop = reg_rd_i & ~reg_sel_i;

  p_cnt_max_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= 5'(DEPTH));

  p_pop_dec_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pop && cnt != 0 && !rx_valid_i |=> cnt == $past(cnt) - 5'd1);

  p_empty_tags_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[14] |-> !status_i[15] && status_i[13:11] == 3'b000);

  p_avail_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[14] == (cnt == 5'd0));

  p_full_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt == 5'(DEPTH) && rx_valid_i && !rd_pop |=> cnt == 5'(DEPTH) && status_i[10]);

  p_err_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && (rx_ferr_i || rx_perr_i) |=> status_i[10]);

  p_tout_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_timeout_i |=> status_i[9]);

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[9] && !(reg_wr_i && reg_sel_i && !reg_wdata_i[9]) |=> status_i[9]);

  p_irq_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[10:6] != 5'd0 |-> irq_i);
endmodule

bind rxfifo_status_ctrl rxs_status_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_valid_i   (rx_valid_i),
  .rx_ferr_i    (rx_ferr_i),
  .rx_perr_i    (rx_perr_i),
  .rx_timeout_i (rx_timeout_i),
  .reg_sel_i    (reg_sel_i),
  .reg_rd_i     (reg_rd_i),
  .reg_wr_i     (reg_wr_i),
  .reg_wdata_i  (reg_wdata_i),
  .status_i     (status_o),
  .irq_i        (irq_o)
);

// File: tb/sim_rxfifo_status_ctrl.sv
`timescale 1ns/1ps
module sim_rxfifo_status_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        rx_brk_i = 1'b0, rx_ferr_i = 1'b0, rx_perr_i = 1'b0;
  logic        rx_timeout_i = 1'b0;
  logic [4:0]  tx_free_i = 5'd0, tx_trig_i = 5'd8, rx_trig_i = 5'd16;
  logic [3:0]  stat_mask_i = 4'd0;
  logic        reg_sel_i = 1'b0, reg_rd_i = 1'b0, reg_wr_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o, status_o;
  logic        irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  rxfifo_status_ctrl u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FIFO-STATUS FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic b, input logic f, input logic p);
    rx_valid_i = 1; rx_data_i = d; rx_brk_i = b; rx_ferr_i = f; rx_perr_i = p;
    @(negedge clk_i);
    rx_valid_i = 0; rx_brk_i = 0; rx_ferr_i = 0; rx_perr_i = 0;
  endtask

  task automatic pop(output logic [7:0] d);
    reg_sel_i = 0; reg_rd_i = 1;
    #1 d = reg_rdata_o[7:0];
    @(negedge clk_i);
    reg_rd_i = 0;
  endtask

  task automatic wr_stat(input logic [31:0] w);
    reg_sel_i = 1; reg_wr_i = 1; reg_wdata_i = w;
    @(negedge clk_i);
    reg_wr_i = 0; reg_sel_i = 0;
  endtask

  task automatic pulse_tout();
    rx_timeout_i = 1;
    @(negedge clk_i);
    rx_timeout_i = 0;
  endtask

  task automatic t_reset();
    check("R12 reset word", status_o, 32'h0000_4100);
    check("R3 empty after reset", {31'd0, status_o[14]}, 32'd1);
    check("R7 txreq after reset", {31'd0, status_o[8]}, 32'd1);
    reg_sel_i = 1; #1;
    check("R12 rdata status view", reg_rdata_o, 32'h0000_4100);
    reg_sel_i = 0;
    wr_stat(32'h0);
    check("R10 clear all", status_o, 32'h0000_4000);
    check("R11 irq low", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_fifo_order();
    logic [7:0] d;
    push(8'hA5, 1, 0, 0);
    check("R5 break alone no err", {31'd0, status_o[10]}, 32'd0);
    push(8'h3C, 0, 1, 0);
    check("R5 framing sets err", {31'd0, status_o[10]}, 32'd1);
    check("R11 irq high", {31'd0, irq_o}, 32'd1);
    push(8'h77, 0, 0, 1);
    check("R1 count 3", {27'd0, status_o[4:0]}, 32'd3);
    check("R3 not empty", {31'd0, status_o[14]}, 32'd0);
    check("R2 head break", {16'd0, status_o[15:11], 11'd0}, 32'h0000_8000);
    pop(d); check("R1 first out", {24'd0, d}, 32'hA5);
    check("R2 head framing", {16'd0, status_o[15:11], 11'd0}, 32'h0000_2000);
    pop(d); check("R1 second out", {24'd0, d}, 32'h3C);
    check("R2 head parity", {16'd0, status_o[15:11], 11'd0}, 32'h0000_1000);
    pop(d); check("R1 third out", {24'd0, d}, 32'h77);
    check("R2 empty tags", {16'd0, status_o[15:11], 11'd0}, 32'h0000_4000);
    check("R12 reserved zero", {status_o[31:16], 10'd0, status_o[5], 5'd0}, 32'd0);
    wr_stat(32'h0);
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    for (int i = 0; i < 16; i++) push(8'(i), 0, 0, 0);
    check("R1 full count", {27'd0, status_o[4:0]}, 32'd16);
    check("R5 no err before overrun", {31'd0, status_o[10]}, 32'd0);
    push(8'hEE, 0, 0, 0);
    check("R4 count held", {27'd0, status_o[4:0]}, 32'd16);
    check("R5 overrun sets err", {31'd0, status_o[10]}, 32'd1);
    for (int i = 0; i < 15; i++) begin
      check("R4 early entry untagged", {31'd0, status_o[11]}, 32'd0);
      pop(d);
      check("R1 drain order", {24'd0, d}, 32'(i));
    end
    check("R4 last entry tagged", {31'd0, status_o[11]}, 32'd1);
    pop(d);
    check("R4 dropped char absent", {24'd0, d}, 32'h0F);
    check("R2 tag gone when empty", {31'd0, status_o[11]}, 32'd0);
    wr_stat(32'h0);
  endtask

  task automatic t_full_pushpop();
    logic [7:0] d;
    for (int i = 0; i < 16; i++) push(8'h40 + 8'(i), 0, 0, 0);
    wr_stat(32'h0);
    rx_valid_i = 1; rx_data_i = 8'h99; reg_sel_i = 0; reg_rd_i = 1;
    #1 d = reg_rdata_o[7:0];
    @(negedge clk_i);
    rx_valid_i = 0; reg_rd_i = 0;
    check("R4 simultaneous pop data", {24'd0, d}, 32'h40);
    check("R4 simultaneous count", {27'd0, status_o[4:0]}, 32'd16);
    check("R4 simultaneous no err", {31'd0, status_o[10]}, 32'd0);
    for (int i = 1; i < 16; i++) pop(d);
    check("R4 tail before new", {24'd0, d}, 32'h4F);
    check("R4 new char untagged", {31'd0, status_o[11]}, 32'd0);
    pop(d);
    check("R4 new char stored", {24'd0, d}, 32'h99);
    wr_stat(32'h0);
  endtask

  task automatic t_set_wins();
    rx_timeout_i = 1; reg_sel_i = 1; reg_wr_i = 1; reg_wdata_i = 32'h0;
    @(negedge clk_i);
    rx_timeout_i = 0; reg_wr_i = 0; reg_sel_i = 0;
    check("R10 set beats clear", {31'd0, status_o[9]}, 32'd1);
    check("R6 timeout latched", {31'd0, status_o[9]}, 32'd1);
    wr_stat(32'hFFFF_FFFF);
    check("R10 write one keeps", status_o, 32'h0000_4200);
    wr_stat(32'h0);
    check("R10 write zero clears", {31'd0, status_o[9]}, 32'd0);
  endtask

  task automatic t_triggers();
    logic [7:0] d;
    rx_trig_i = 5'd3;
    push(8'h01, 0, 0, 0); push(8'h02, 0, 0, 0);
    @(negedge clk_i);
    check("R8 below level", {31'd0, status_o[7]}, 32'd0);
    push(8'h03, 0, 0, 0);
    check("R8 one edge late", {31'd0, status_o[7]}, 32'd0);
    @(negedge clk_i);
    check("R8 at level", {31'd0, status_o[7]}, 32'd1);
    wr_stat(32'h0);
    check("R10 clear loses to level", {31'd0, status_o[7]}, 32'd1);
    pop(d);
    wr_stat(32'h0);
    check("R8 cleared below level", {31'd0, status_o[7]}, 32'd0);
    pop(d); pop(d);
    rx_trig_i = 5'd16;
    tx_trig_i = 5'd6; tx_free_i = 5'd5;
    @(negedge clk_i); @(negedge clk_i);
    check("R7 below level", {31'd0, status_o[8]}, 32'd0);
    tx_free_i = 5'd6;
    @(negedge clk_i);
    check("R7 at level", {31'd0, status_o[8]}, 32'd1);
    tx_free_i = 5'd0;
    wr_stat(32'h0);
  endtask

  task automatic t_stchg();
    stat_mask_i = 4'b0100;
    pulse_tout();
    check("R9 selected source", {30'd0, status_o[9], status_o[6]}, 32'd3);
    wr_stat(32'h0);
    stat_mask_i = 4'b0000;
    pulse_tout();
    check("R9 masked off", {30'd0, status_o[9], status_o[6]}, 32'd2);
    wr_stat(32'h0);
    stat_mask_i = 4'b1000;
    pulse_tout();
    check("R9 other source", {31'd0, status_o[6]}, 32'd0);
    wr_stat(32'h0);
    check("R11 irq after clear", {31'd0, irq_o}, 32'd0);
    stat_mask_i = 4'b0000;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_fifo_order();
    t_overrun();
    t_full_pushpop();
    t_set_wins();
    t_triggers();
    t_stchg();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FIFO-STATUS FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule